// File: doc/BRIEF.md
# Rolled Double SHA-256 Nonce Search Engine

The engine searches a 32-bit nonce space for a block header whose double SHA-256 digest ends in a zero word. The host hands it the compression state left over after hashing the first 64-byte chunk of the header, the three fixed words of the second chunk and a first nonce. After a start pulse the engine walks the nonces upward. For each nonce it runs one compression over the second chunk, pads the resulting 256-bit digest into a fresh block and compresses that block from the standard initial values.

The datapath is rolled: a chain of 2^UNROLL_LOG2 round stages (two by default) is applied once per clock, with a 16-word sliding message window beside it. Two schedule words of the first pass do not involve the nonce. They are worked out once when work is loaded and reused for every nonce of that work unit. The second pass ends after round 61, because the last digest word is already fixed by then: it is the E register after round 61 plus the last initial value. A hit stops the engine and gives a one-cycle pulse with the nonce. A sticky lamp output stays lit until new work arrives.

Top module: `dsha_nonce_engine`

## Requirements
- R1: After synchronous reset, busy, found, hit_led and found_nonce are all zero.
- R2: While idle, a load pulse captures midstate (mid_i[255:224] is the first state word), the three chunk words (tail_i[95:64] is word 0) and the first nonce, and clears hit_led. Load has priority over start in the same cycle. A load while busy is ignored and the search in progress is unchanged.
- R3: The second chunk is the three tail words, then the nonce as word 3, then 0x80000000, ten zero words and 0x00000280. The outer block is the eight digest words, then 0x80000000, six zero words and 0x00000100. A nonce hits when the top ZERO_BITS bits of the final digest word 7 are zero; the default of 32 means the whole word is zero.
- R4: Nonces are tried in ascending order from the current nonce, and the first hit is reported. On that edge found is high for exactly one cycle, found_nonce holds the hit, and busy falls.
- R5: A start pulse after a hit resumes the search at the hit nonce plus one.
- R6: If nonce 0xFFFFFFFF is tried without a hit, busy falls with no found pulse. The next start begins at nonce 0.
- R7: busy rises on the edge that samples start. Each nonce takes 64/U + ceil(61/U) cycles, where U = 2^UNROLL_LOG2 (63 at the default). The result of the k-th nonce tried is visible k times that many edges after the start edge.
- R8: hit_led is set by a hit and stays set through later searches until the next accepted load.
- R9: A start pulse while busy has no effect on the search or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture new work (idle only) |
| mid_i | input | 256 | State after the first header chunk |
| tail_i | input | 96 | Fixed words 0..2 of the second chunk |
| nonce_i | input | 32 | First nonce of the work unit |
| start | input | 1 | Begin or resume the search |
| busy | output | 1 | Search in progress |
| found | output | 1 | One-cycle hit pulse |
| found_nonce | output | 32 | Nonce of the last hit |
| hit_led | output | 1 | Sticky hit indicator |

## Verification
A historical header with a known all-zero final word is run on the full 32-bit criterion. This shows that the chunk layout, the padding, the precomputed words and the early exit at round 61 agree with a complete double hash. Random midstates, tail words and first nonces on a build that needs only six zero bits produce hits at varied distances, which test the search order and the cycle count against a software model. Directed cases start near the top of the nonce range to show the stop on wrap and the restart from zero. They also resume after a hit, and they apply load and start while busy to show that neither disturbs the running search.

// File: rtl/dsha_pkg.sv
package dsha_pkg;
  typedef logic [31:0] word_t;
  typedef logic [15:0][31:0] win_t;
  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } hstate_t;

  localparam hstate_t INIT_ST = hstate_t'({32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372,
    32'ha54ff53a, 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19});

  function automatic word_t rotr(input word_t x, input int n);
    rotr = (x >> n) | (x << (32 - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    big_s0 = rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    big_s1 = rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(input word_t x);
    sml_s0 = rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(input word_t x);
    sml_s1 = rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t rk(input logic [5:0] i);
    case (i)
      6'd0:  rk = 32'h428a2f98; 6'd1:  rk = 32'h71374491; 6'd2:  rk = 32'hb5c0fbcf; 6'd3:  rk = 32'he9b5dba5;
      6'd4:  rk = 32'h3956c25b; 6'd5:  rk = 32'h59f111f1; 6'd6:  rk = 32'h923f82a4; 6'd7:  rk = 32'hab1c5ed5;
      6'd8:  rk = 32'hd807aa98; 6'd9:  rk = 32'h12835b01; 6'd10: rk = 32'h243185be; 6'd11: rk = 32'h550c7dc3;
      6'd12: rk = 32'h72be5d74; 6'd13: rk = 32'h80deb1fe; 6'd14: rk = 32'h9bdc06a7; 6'd15: rk = 32'hc19bf174;
      6'd16: rk = 32'he49b69c1; 6'd17: rk = 32'hefbe4786; 6'd18: rk = 32'h0fc19dc6; 6'd19: rk = 32'h240ca1cc;
      6'd20: rk = 32'h2de92c6f; 6'd21: rk = 32'h4a7484aa; 6'd22: rk = 32'h5cb0a9dc; 6'd23: rk = 32'h76f988da;
      6'd24: rk = 32'h983e5152; 6'd25: rk = 32'ha831c66d; 6'd26: rk = 32'hb00327c8; 6'd27: rk = 32'hbf597fc7;
      6'd28: rk = 32'hc6e00bf3; 6'd29: rk = 32'hd5a79147; 6'd30: rk = 32'h06ca6351; 6'd31: rk = 32'h14292967;
      6'd32: rk = 32'h27b70a85; 6'd33: rk = 32'h2e1b2138; 6'd34: rk = 32'h4d2c6dfc; 6'd35: rk = 32'h53380d13;
      6'd36: rk = 32'h650a7354; 6'd37: rk = 32'h766a0abb; 6'd38: rk = 32'h81c2c92e; 6'd39: rk = 32'h92722c85;
      6'd40: rk = 32'ha2bfe8a1; 6'd41: rk = 32'ha81a664b; 6'd42: rk = 32'hc24b8b70; 6'd43: rk = 32'hc76c51a3;
      6'd44: rk = 32'hd192e819; 6'd45: rk = 32'hd6990624; 6'd46: rk = 32'hf40e3585; 6'd47: rk = 32'h106aa070;
      6'd48: rk = 32'h19a4c116; 6'd49: rk = 32'h1e376c08; 6'd50: rk = 32'h2748774c; 6'd51: rk = 32'h34b0bcb5;
      6'd52: rk = 32'h391c0cb3; 6'd53: rk = 32'h4ed8aa4a; 6'd54: rk = 32'h5b9cca4f; 6'd55: rk = 32'h682e6ff3;
      6'd56: rk = 32'h748f82ee; 6'd57: rk = 32'h78a5636f; 6'd58: rk = 32'h84c87814; 6'd59: rk = 32'h8cc70208;
      6'd60: rk = 32'h90befffa; 6'd61: rk = 32'ha4506ceb; 6'd62: rk = 32'hbef9a3f7; default: rk = 32'hc67178f2;
    endcase
  endfunction

  // inner chunk: three fixed words, nonce in word 3, padding, 640-bit length
  function automatic win_t inner_blk(input logic [95:0] tl, input word_t n);
    inner_blk = '0;
    inner_blk[0] = tl[95:64];
    inner_blk[1] = tl[63:32];
    inner_blk[2] = tl[31:0];
    inner_blk[3] = n;
    inner_blk[4] = 32'h80000000;
    inner_blk[15] = 32'h00000280;
  endfunction

  // outer block: 256-bit digest, padding, 256-bit length
  function automatic win_t outer_blk(input hstate_t d);
    outer_blk = '0;
    outer_blk[0] = d.a; outer_blk[1] = d.b; outer_blk[2] = d.c; outer_blk[3] = d.d;
    outer_blk[4] = d.e; outer_blk[5] = d.f; outer_blk[6] = d.g; outer_blk[7] = d.h;
    outer_blk[8] = 32'h80000000;
    outer_blk[15] = 32'h00000100;
  endfunction

  function automatic hstate_t add_st(input hstate_t x, input hstate_t y);
    add_st.a = x.a + y.a; add_st.b = x.b + y.b; add_st.c = x.c + y.c; add_st.d = x.d + y.d;
    add_st.e = x.e + y.e; add_st.f = x.f + y.f; add_st.g = x.g + y.g; add_st.h = x.h + y.h;
  endfunction
endpackage

// File: rtl/dsha_round.sv
module dsha_round
  import dsha_pkg::*;
(
  input  hstate_t    s_i,
  input  word_t      w_i,
  input  logic [5:0] t_i,
  output hstate_t    s_o
);
  word_t t1, t2, ch, mj;

  always_comb begin
    ch = (s_i.e & s_i.f) ^ (~s_i.e & s_i.g);
    mj = (s_i.a & s_i.b) ^ (s_i.a & s_i.c) ^ (s_i.b & s_i.c);
    t1 = s_i.h + big_s1(s_i.e) + ch + rk(t_i) + w_i;
    t2 = big_s0(s_i.a) + mj;
    s_o.a = t1 + t2;
    s_o.b = s_i.a;
    s_o.c = s_i.b;
    s_o.d = s_i.c;
    s_o.e = s_i.d + t1;
    s_o.f = s_i.e;
    s_o.g = s_i.f;
    s_o.h = s_i.g;
  end
endmodule

// File: rtl/dsha_sched_step.sv
module dsha_sched_step
  import dsha_pkg::*;
(
  input  win_t  win_i,
  input  logic  use_a_i,
  input  logic  use_b_i,
  input  word_t pre_a_i,
  input  word_t pre_b_i,
  output win_t  win_o
);
  word_t nxt;

  always_comb begin
    if (use_a_i)      nxt = pre_a_i;
    else if (use_b_i) nxt = pre_b_i;
    else              nxt = sml_s1(win_i[14]) + win_i[9] + sml_s0(win_i[1]) + win_i[0];
    win_o = {nxt, win_i[15:1]};
  end
endmodule

// File: rtl/dsha_precomp.sv
module dsha_precomp
  import dsha_pkg::*;
(
  input  logic [95:0] tail_i,
  output word_t       w16_o,
  output word_t       w17_o
);
  // words 9, 10 and 14 are zero; word 15 is the fixed length word
  assign w16_o = tail_i[95:64] + sml_s0(tail_i[63:32]);
  assign w17_o = tail_i[63:32] + sml_s0(tail_i[31:0]) + sml_s1(32'h00000280);
endmodule

// File: rtl/dsha_nonce_engine.sv
module dsha_nonce_engine
  import dsha_pkg::*;
#(
  parameter int UNROLL_LOG2 = 1,
  parameter int ZERO_BITS   = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [255:0] mid_i,
  input  logic [95:0]  tail_i,
  input  logic [31:0]  nonce_i,
  input  logic         start,
  output logic         busy,
  output logic         found,
  output logic [31:0]  found_nonce,
  output logic         hit_led
);
  localparam int U = 1 << UNROLL_LOG2;
  localparam logic [7:0] STEP = 8'(U);

  logic [255:0] mid_q;
  logic [95:0]  tail_q;
  word_t        nonce_q, pre_a_q, pre_b_q, w16_c, w17_c;
  hstate_t      state_q;
  win_t         win_q;
  logic [6:0]   rnd_q;
  logic         pass_q, busy_q, found_q, led_q;
  logic [31:0]  fnon_q;

  hstate_t st_c [U+1];
  win_t    win_c [U+1];
  word_t   e61, fin7;
  logic    hit, p0_end, p1_end;
  logic [7:0] rnd_sum;

  dsha_precomp u_pre (.tail_i(tail_i), .w16_o(w16_c), .w17_o(w17_c));

  assign st_c[0]  = state_q;
  assign win_c[0] = win_q;

  for (genvar j = 0; j < U; j++) begin : g_stage
    logic [7:0] t_j;
    assign t_j = {1'b0, rnd_q} + 8'(j);
    dsha_round u_rnd (.s_i(st_c[j]), .w_i(win_c[j][0]), .t_i(t_j[5:0]), .s_o(st_c[j+1]));
    dsha_sched_step u_sch (
      .win_i(win_c[j]), .use_a_i(!pass_q && t_j == 8'd0), .use_b_i(!pass_q && t_j == 8'd1),
      .pre_a_i(pre_a_q), .pre_b_i(pre_b_q), .win_o(win_c[j+1]));
  end

  // E after outer round 61 is H after round 64
  always_comb begin
    e61 = '0;
    for (int j = 0; j < U; j++)
      if ({1'b0, rnd_q} + 8'(j) == 8'd60) e61 = st_c[j+1].e;
    fin7    = e61 + INIT_ST.h;
    hit     = ((fin7 >> (32 - ZERO_BITS)) == 32'd0);
    rnd_sum = {1'b0, rnd_q} + STEP;
    p0_end  = !pass_q && rnd_sum == 8'd64;
    p1_end  = pass_q && rnd_sum >= 8'd61;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q <= '0; tail_q <= '0; nonce_q <= '0; pre_a_q <= '0; pre_b_q <= '0;
      state_q <= '0; win_q <= '0; rnd_q <= '0; pass_q <= 1'b0;
      busy_q <= 1'b0; found_q <= 1'b0; led_q <= 1'b0; fnon_q <= '0;
    end else begin
      found_q <= 1'b0;
      if (!busy_q) begin
        if (load) begin
          mid_q <= mid_i; tail_q <= tail_i; nonce_q <= nonce_i;
          pre_a_q <= w16_c; pre_b_q <= w17_c; led_q <= 1'b0;
        end else if (start) begin
          busy_q <= 1'b1; pass_q <= 1'b0; rnd_q <= '0;
          state_q <= hstate_t'(mid_q); win_q <= inner_blk(tail_q, nonce_q);
        end
      end else if (p0_end) begin
        pass_q <= 1'b1; rnd_q <= '0; state_q <= INIT_ST;
        win_q <= outer_blk(add_st(hstate_t'(mid_q), st_c[U]));
      end else if (p1_end) begin
        nonce_q <= nonce_q + 32'd1;
        if (hit) begin
          found_q <= 1'b1; fnon_q <= nonce_q; led_q <= 1'b1; busy_q <= 1'b0;
        end else if (nonce_q == 32'hFFFFFFFF) begin
          busy_q <= 1'b0;
        end else begin
          pass_q <= 1'b0; rnd_q <= '0; state_q <= hstate_t'(mid_q);
          win_q <= inner_blk(tail_q, nonce_q + 32'd1);
        end
      end else begin
        state_q <= st_c[U]; win_q <= win_c[U]; rnd_q <= rnd_sum[6:0];
      end
    end
  end

  assign busy        = busy_q;
  assign found       = found_q;
  assign found_nonce = fnon_q;
  assign hit_led     = led_q;

  AST_FOUND_IDLE: assert property (@(posedge clk) disable iff (rst) found |-> !busy); // R4
  AST_FOUND_ONE:  assert property (@(posedge clk) disable iff (rst) found |=> !found); // R4
  AST_LED_SET:    assert property (@(posedge clk) disable iff (rst) found |-> hit_led); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start)); // R9
  AST_WORK_HOLD:  assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(mid_q)); // R2
  AST_ROUND_BOUND: assert property (@(posedge clk) disable iff (rst) busy |-> rnd_q < 7'd64); // R7
endmodule

// File: tb/dsha_nonce_engine_bench.sv
module dsha_nonce_engine_bench;
  localparam int CPN = 63;  // 64/2 + ceil(61/2) at the default unroll

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] ld = '0, st = '0;
  logic [255:0] mid = '0;
  logic [95:0] tail = '0;
  logic [31:0] n0 = '0;
  logic [1:0] bsy, fnd, led;
  logic [31:0] fnon [2];
  int checks = 0, errors = 0, cyc_all = 0;

  always #2 clk = ~clk;

  dsha_nonce_engine u_dsha_nonce_engine (
    .clk(clk), .rst(rst), .load(ld[0]), .mid_i(mid), .tail_i(tail), .nonce_i(n0), .start(st[0]),
    .busy(bsy[0]), .found(fnd[0]), .found_nonce(fnon[0]), .hit_led(led[0]));

  dsha_nonce_engine #(.ZERO_BITS(6)) u_dsha_nonce_engine_easy (
    .clk(clk), .rst(rst), .load(ld[1]), .mid_i(mid), .tail_i(tail), .nonce_i(n0), .start(st[1]),
    .busy(bsy[1]), .found(fnd[1]), .found_nonce(fnon[1]), .hit_led(led[1]));

  // ---------------- software model ----------------
  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    rr = (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] kc(input int i);
    case (i)
      0: kc = 32'h428a2f98; 1: kc = 32'h71374491; 2: kc = 32'hb5c0fbcf; 3: kc = 32'he9b5dba5;
      4: kc = 32'h3956c25b; 5: kc = 32'h59f111f1; 6: kc = 32'h923f82a4; 7: kc = 32'hab1c5ed5;
      8: kc = 32'hd807aa98; 9: kc = 32'h12835b01; 10: kc = 32'h243185be; 11: kc = 32'h550c7dc3;
      12: kc = 32'h72be5d74; 13: kc = 32'h80deb1fe; 14: kc = 32'h9bdc06a7; 15: kc = 32'hc19bf174;
      16: kc = 32'he49b69c1; 17: kc = 32'hefbe4786; 18: kc = 32'h0fc19dc6; 19: kc = 32'h240ca1cc;
      20: kc = 32'h2de92c6f; 21: kc = 32'h4a7484aa; 22: kc = 32'h5cb0a9dc; 23: kc = 32'h76f988da;
      24: kc = 32'h983e5152; 25: kc = 32'ha831c66d; 26: kc = 32'hb00327c8; 27: kc = 32'hbf597fc7;
      28: kc = 32'hc6e00bf3; 29: kc = 32'hd5a79147; 30: kc = 32'h06ca6351; 31: kc = 32'h14292967;
      32: kc = 32'h27b70a85; 33: kc = 32'h2e1b2138; 34: kc = 32'h4d2c6dfc; 35: kc = 32'h53380d13;
      36: kc = 32'h650a7354; 37: kc = 32'h766a0abb; 38: kc = 32'h81c2c92e; 39: kc = 32'h92722c85;
      40: kc = 32'ha2bfe8a1; 41: kc = 32'ha81a664b; 42: kc = 32'hc24b8b70; 43: kc = 32'hc76c51a3;
      44: kc = 32'hd192e819; 45: kc = 32'hd6990624; 46: kc = 32'hf40e3585; 47: kc = 32'h106aa070;
      48: kc = 32'h19a4c116; 49: kc = 32'h1e376c08; 50: kc = 32'h2748774c; 51: kc = 32'h34b0bcb5;
      52: kc = 32'h391c0cb3; 53: kc = 32'h4ed8aa4a; 54: kc = 32'h5b9cca4f; 55: kc = 32'h682e6ff3;
      56: kc = 32'h748f82ee; 57: kc = 32'h78a5636f; 58: kc = 32'h84c87814; 59: kc = 32'h8cc70208;
      60: kc = 32'h90befffa; 61: kc = 32'ha4506ceb; 62: kc = 32'hbef9a3f7; default: kc = 32'hc67178f2;
    endcase
  endfunction

  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  function automatic logic [255:0] cmp(input logic [255:0] h, input logic [511:0] b);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    for (int i = 0; i < 16; i++) w[i] = b[511-32*i -: 32];
    for (int i = 16; i < 64; i++)
      w[i] = (rr(w[i-2],17) ^ rr(w[i-2],19) ^ (w[i-2] >> 10)) + w[i-7]
           + (rr(w[i-15],7) ^ rr(w[i-15],18) ^ (w[i-15] >> 3)) + w[i-16];
    for (int i = 0; i < 8; i++) v[i] = h[255-32*i -: 32];
    for (int i = 0; i < 64; i++) begin
      t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25)) + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kc(i) + w[i];
      t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22)) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) cmp[255-32*i -: 32] = h[255-32*i -: 32] + v[i];
  endfunction

  function automatic logic [31:0] final_w7(input logic [255:0] m, input logic [95:0] t, input logic [31:0] n);
    logic [255:0] d1, d2;
    d1 = cmp(m, {t, n, 32'h80000000, 320'd0, 32'h00000280});
    d2 = cmp(IV, {d1, 32'h80000000, 192'd0, 32'h00000100});
    final_w7 = d2[31:0];
  endfunction

  // first hit at or after s within lim tries; stops after 0xFFFFFFFF
  function automatic bit search(input logic [255:0] m, input logic [95:0] t, input logic [31:0] s,
                                input int lim, input int zb, output logic [31:0] hn, output int tries);
    logic [31:0] n;
    hn = '0; tries = 0;
    for (int i = 0; i < lim; i++) begin
      n = s + 32'(i);
      tries = i + 1;
      if ((final_w7(m, t, n) >> (32 - zb)) == 32'd0) begin hn = n; return 1'b1; end
      if (n == 32'hFFFFFFFF) return 1'b0;
    end
    return 1'b0;
  endfunction

  // ---------------- bench helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input int k, input logic [255:0] m, input logic [95:0] t, input logic [31:0] n);
    @(negedge clk); mid = m; tail = t; n0 = n; ld[k] = 1'b1;
    @(negedge clk); ld[k] = 1'b0;
  endtask

  task automatic do_start(input int k);
    @(negedge clk); st[k] = 1'b1;
    @(negedge clk); st[k] = 1'b0;
  endtask

  task automatic wait_done(input int k, input int maxc, output int cyc, output bit got);
    cyc = 0; got = 1'b0;
    while (cyc < maxc) begin
      @(negedge clk); cyc++;
      if (fnd[k]) begin got = 1'b1; return; end
      if (!bsy[k]) return;
    end
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 190000", cyc_all);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] m, mb;
    logic [95:0] t;
    logic [31:0] s, hn, hn2;
    int tries, tries2, cyc;
    bit ok, got;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 2; k++) begin
      chk(bsy[k] == 1'b0, "R1 busy", 32'(bsy[k]), 0);
      chk(fnd[k] == 1'b0, "R1 found", 32'(fnd[k]), 0);
      chk(led[k] == 1'b0, "R1 led", 32'(led[k]), 0);
      chk(fnon[k] == 32'd0, "R1 found_nonce", fnon[k], 0);
    end

    // R3 historical header: whole final word zero at nonce 0x1dac2b7c
    m = cmp(IV, {32'h01000000, 256'd0, 32'h3ba3edfd, 32'h7a7b12b2, 32'h7ac72c3e,
                 32'h67768f61, 32'h7fc81bc3, 32'h888a5132, 32'h3a9fb8aa});
    t = {32'h4b1e5e4a, 32'h29ab5f49, 32'hffff001d};
    chk(final_w7(m, t, 32'h1dac2b7c) == 32'd0, "R3 model zero word", final_w7(m, t, 32'h1dac2b7c), 0);
    ok = search(m, t, 32'h1dac2b79, 4, 32, hn, tries);
    do_load(0, m, t, 32'h1dac2b79);
    do_start(0);
    wait_done(0, 10 * CPN, cyc, got);
    chk(got == ok, "R3 full-word hit", 32'(got), 32'(ok));
    chk(fnon[0] == hn, "R3 R4 hit nonce", fnon[0], hn);
    chk(cyc == tries * CPN, "R7 cycles to hit", 32'(cyc), 32'(tries * CPN));
    chk(bsy[0] == 1'b0, "R4 busy falls", 32'(bsy[0]), 0);
    chk(led[0] == 1'b1, "R8 led set", 32'(led[0]), 1);
    @(negedge clk);
    chk(fnd[0] == 1'b0, "R4 single pulse", 32'(fnd[0]), 0);

    // R4 R7 random work units on the six-zero-bit build
    for (int it = 0; it < 5; it++) begin
      m = rnd256(); t = {$urandom, $urandom, $urandom}; s = $urandom & 32'h7FFFFFFF;
      ok = search(m, t, s, 3000, 6, hn, tries);
      do_load(1, m, t, s);
      do_start(1);
      wait_done(1, 3100 * CPN, cyc, got);
      chk(got == ok, "R4 random hit", 32'(got), 32'(ok));
      chk(fnon[1] == hn, "R4 random nonce", fnon[1], hn);
      chk(cyc == tries * CPN, "R7 random cycles", 32'(cyc), 32'(tries * CPN));
    end

    // R5 resume after hit; R8 led survives resume
    ok = search(m, t, hn + 32'd1, 3000, 6, hn2, tries2);
    do_start(1);
    wait_done(1, 3100 * CPN, cyc, got);
    chk(got == ok, "R5 resume hit", 32'(got), 32'(ok));
    chk(fnon[1] == hn2, "R5 resume nonce", fnon[1], hn2);
    chk(cyc == tries2 * CPN, "R5 resume cycles", 32'(cyc), 32'(tries2 * CPN));
    chk(led[1] == 1'b1, "R8 led sticky", 32'(led[1]), 1);

    // R2 R9 load and start while busy are ignored
    m = rnd256(); t = {$urandom, $urandom, $urandom}; s = $urandom;
    s = s & 32'h7FFFFFFF;
    ok = search(m, t, s, 3000, 6, hn, tries);
    do_load(1, m, t, s);
    chk(led[1] == 1'b0, "R8 led cleared by load", 32'(led[1]), 0);
    do_start(1);
    repeat (5) @(negedge clk);
    mb = rnd256(); mid = mb; tail = ~t; n0 = ~s; ld[1] = 1'b1;
    @(negedge clk); ld[1] = 1'b0; st[1] = 1'b1;
    @(negedge clk); st[1] = 1'b0;
    wait_done(1, 3100 * CPN, cyc, got);
    chk(got == ok, "R2 hit after busy load", 32'(got), 32'(ok));
    chk(fnon[1] == hn, "R2 nonce unchanged by busy load", fnon[1], hn);
    chk(cyc + 7 == tries * CPN, "R9 timing unchanged by busy start", 32'(cyc + 7), 32'(tries * CPN));

    // R6 wrap at top of nonce range
    ok = 1'b1;
    for (int a = 0; a < 60 && ok; a++) begin
      m = rnd256(); t = {$urandom, $urandom, $urandom};
      ok = search(m, t, 32'hFFFFFFF0, 16, 6, hn, tries);
    end
    do_load(1, m, t, 32'hFFFFFFF0);
    do_start(1);
    wait_done(1, 20 * CPN, cyc, got);
    chk(got == ok, "R6 no hit at wrap", 32'(got), 32'(ok));
    if (!ok) chk(cyc == 16 * CPN, "R6 busy falls after last nonce", 32'(cyc), 32'(16 * CPN));
    ok = search(m, t, 32'd0, 3000, 6, hn, tries);
    do_start(1);
    wait_done(1, 3100 * CPN, cyc, got);
    chk(got == ok, "R6 restart from zero hit", 32'(got), 32'(ok));
    chk(fnon[1] == hn, "R6 restart nonce", fnon[1], hn);
    chk(cyc == tries * CPN, "R6 restart cycles", 32'(cyc), 32'(tries * CPN));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule